// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides when the external memory bus is handed to an outside master and when it is taken back. The chip owns the bus by default. An outside master asks for the bus by pulling an active-low release request. The arbiter first waits for the running bus cycle and any DRAM precharge to finish. It then floats the pins in a fixed order, with steps half a clock apart, and answers with an active-low grant. When the request returns high, it restores the pins in the reverse order. While a refresh is waiting and the bus is away, it raises a refresh-waiting output that asks the outside master to give the bus back.

The block runs on one clock at twice the bus-clock rate. An internal phase bit marks each edge as either a rise slot or a fall slot of the bus clock. The first edge after reset is a rise slot, and the slots alternate from there. The release request and the hand-back are acted on only in fall slots. Pin groups are released or restored only in rise slots, with one exception: the grant changes in a fall slot. The surrounding bus-cycle engine reports completion through a cycle-done flag and reads the bus-idle output so that it starts no cycle during a hand-over. The enable outputs drive the pad tri-state controls of two pin groups: the address/data group and the control-strobe group. The park output forces the strobes to their inactive high level.

Top module: `bus_release_arb`

## Requirements
- R1: After reset, grantN, addrDataEn, ctrlEn and busIdle are 1, and ctrlParkHigh and refWaitReq are 0.
- R2: relReqN is sampled only in fall slots. A low level present only during rise slots starts nothing, and busIdle stays 1. A low level seen in a fall slot drops busIdle after that edge.
- R3: After the request is accepted, addrDataEn falls only at a rise slot where cycleDone and prechDone are both 1. While either is 0, all outputs keep their owned values.
- R4: If addrDataEn falls at edge T, grantN falls at edge T+1 (a fall slot) and ctrlEn falls at edge T+2*PARK_CYCLES (a rise slot).
- R5: ctrlParkHigh rises together with the fall of addrDataEn. It stays 1 for at least PARK_CYCLES bus clocks while ctrlEn is still 1, then stays 1 until addrDataEn is restored.
- R6: Once ctrlEn is 0, a high relReqN seen at fall-slot edge F starts the take-back. ctrlEn returns to 1 at edge F+1. grantN returns to 1 at edge F+2. At edge F+3, addrDataEn returns to 1, ctrlParkHigh goes to 0 and busIdle goes to 1.
- R7: If relReqN is seen high in a fall slot while the block still waits for cycleDone and prechDone, the release is abandoned. busIdle returns to 1, and grantN and addrDataEn never leave 1.
- R8: refWaitReq equals refPending while addrDataEn is 0, and is 0 while addrDataEn is 1.
- R9: busIdle is 1 only in the owned state. It is 0 from the edge that accepts a request until the edge that restores addrDataEn. Whenever busIdle is 1, grantN, addrDataEn and ctrlEn are all 1.
- R10: A release that has already dropped addrDataEn always finishes. relReqN going high before ctrlEn falls does not stop ctrlEn from falling at T+2*PARK_CYCLES. The take-back then starts at the next fall slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-clock rate; edges alternate rise slot and fall slot |
| rstN | input | 1 | Asynchronous active-low reset |
| relReqN | input | 1 | Active-low bus release request from the outside master |
| cycleDone | input | 1 | High when the current bus cycle has completed |
| prechDone | input | 1 | High when DRAM precharge, including any active-bank precharge, has completed |
| refPending | input | 1 | High while a refresh is waiting to run |
| grantN | output | 1 | Active-low bus grant to the outside master |
| addrDataEn | output | 1 | Output enable of the address and data pins |
| ctrlEn | output | 1 | Output enable of the control-strobe pins |
| ctrlParkHigh | output | 1 | Forces the control strobes to their inactive high level |
| refWaitReq | output | 1 | Asks the outside master to return the bus for a waiting refresh |
| busIdle | output | 1 | High when the cycle engine may start a new cycle |

## Verification
The assertions assume that every input is stable across each clock edge. They also assume that reset leaves the phase in a rise slot. They assume nothing about when relReqN, cycleDone or prechDone change relative to the arbiter state. The stimulus therefore changes all inputs only at the falling edge of the fast clock. It mixes directed slot-aligned scenarios with long random runs, in which the request toggles rarely and the done flags are random in every slot. These runs reach abandons, precharge stalls and requests withdrawn during the park window.

// File: rtl/brel_pkg.sv
package brel_pkg;

  typedef enum logic [2:0] {
    ST_OWNED,
    ST_WAIT_DONE,
    ST_PARK_HIGH,
    ST_RELEASED,
    ST_RECLAIM_CTRL,
    ST_RECLAIM_GRANT,
    ST_RECLAIM_ADDR
  } brelState_e;

  // One-edge strobes from control to the output registers.
  typedef struct packed {
    logic addrOff;
    logic addrOn;
    logic ctrlOff;
    logic ctrlOn;
    logic grantOn;
    logic grantOff;
  } brelStrobe_t;

endpackage

// File: rtl/brel_ctrl.sv
module brel_ctrl
  import brel_pkg::*;
#(
  parameter int PARK_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        relReqN,
  input  logic        cycleDone,
  input  logic        prechDone,
  output brelStrobe_t stb,
  output logic        busIdle
);

  localparam int CW = (PARK_CYCLES > 1) ? $clog2(PARK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PARK_CYCLES - 1);

  brelState_e stateQ, stateD;
  logic [CW-1:0] cntQ, cntD;
  logic phaseQ;  // 1: this edge is a fall slot
  logic fallSlot;

  assign fallSlot = phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OWNED;
      cntQ   <= '0;
      phaseQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      phaseQ <= ~phaseQ;
    end
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    stb    = '0;
    unique case (stateQ)
      ST_OWNED: begin
        if (fallSlot && !relReqN) stateD = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        if (fallSlot) begin
          if (relReqN) stateD = ST_OWNED;
        end else if (cycleDone && prechDone) begin
          stateD      = ST_PARK_HIGH;
          cntD        = '0;
          stb.addrOff = 1'b1;
        end
      end
      ST_PARK_HIGH: begin
        if (fallSlot) begin
          if (cntQ == '0) stb.grantOn = 1'b1;
        end else if (cntQ == LAST) begin
          stateD      = ST_RELEASED;
          stb.ctrlOff = 1'b1;
        end else begin
          cntD = cntQ + CW'(1);
        end
      end
      ST_RELEASED: begin
        if (fallSlot && relReqN) stateD = ST_RECLAIM_CTRL;
      end
      ST_RECLAIM_CTRL: begin
        if (!fallSlot) begin
          stb.ctrlOn = 1'b1;
          stateD     = ST_RECLAIM_GRANT;
        end
      end
      ST_RECLAIM_GRANT: begin
        if (fallSlot) begin
          stb.grantOff = 1'b1;
          stateD       = ST_RECLAIM_ADDR;
        end
      end
      ST_RECLAIM_ADDR: begin
        if (!fallSlot) begin
          stb.addrOn = 1'b1;
          stateD     = ST_OWNED;
        end
      end
      default: stateD = ST_OWNED;
    endcase
  end

  assign busIdle = (stateQ == ST_OWNED);

  AST_ACCEPT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_DONE && $past(stateQ) == ST_OWNED) |-> ($past(phaseQ) && !$past(relReqN))) else $error("accept outside fall slot"); // R2

  AST_ABANDON_TO_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OWNED && $past(stateQ) == ST_WAIT_DONE) |-> $past(relReqN)) else $error("bad abandon"); // R7

endmodule

// File: rtl/brel_datapath.sv
module brel_datapath
  import brel_pkg::*;
#(
  parameter int PARK_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  brelStrobe_t stb,
  input  logic        refPending,
  output logic        grantN,
  output logic        addrDataEn,
  output logic        ctrlEn,
  output logic        ctrlParkHigh,
  output logic        refWaitReq
);

  localparam int PW = $clog2(2 * PARK_CYCLES + 2);
  localparam logic [PW-1:0] MIN_PARK = PW'(2 * PARK_CYCLES);

  logic grantNQ, addrEnQ, ctrlEnQ, parkQ;
  logic [PW-1:0] parkTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantNQ <= 1'b1;
      addrEnQ <= 1'b1;
      ctrlEnQ <= 1'b1;
      parkQ   <= 1'b0;
    end else begin
      if (stb.grantOn)  grantNQ <= 1'b0;
      if (stb.grantOff) grantNQ <= 1'b1;
      if (stb.addrOff) begin
        addrEnQ <= 1'b0;
        parkQ   <= 1'b1;
      end
      if (stb.addrOn) begin
        addrEnQ <= 1'b1;
        parkQ   <= 1'b0;
      end
      if (stb.ctrlOff) ctrlEnQ <= 1'b0;
      if (stb.ctrlOn)  ctrlEnQ <= 1'b1;
    end
  end

  // Edges spent driving strobes high while still enabled (guards R5).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           parkTicks <= '0;
    else if (!parkQ)                     parkTicks <= '0;
    else if (ctrlEnQ && parkTicks != '1) parkTicks <= parkTicks + PW'(1);
  end

  assign grantN       = grantNQ;
  assign addrDataEn   = addrEnQ;
  assign ctrlEn       = ctrlEnQ;
  assign ctrlParkHigh = parkQ;
  assign refWaitReq   = refPending && !addrEnQ;

  AST_GRANT_AFTER_ADDR_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    !grantNQ |-> !addrEnQ) else $error("grant with address driven"); // R4

  AST_CTRL_FLOAT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnQ |-> !grantNQ) else $error("strobes float before grant"); // R4

  AST_PARK_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlEnQ) |-> (parkTicks >= MIN_PARK)) else $error("park window too short"); // R5

  AST_ADDR_AFTER_GRANT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrEnQ) |-> ($past(grantNQ) && ctrlEnQ)) else $error("address back too early"); // R6

  AST_GRANT_OFF_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantNQ) |-> (ctrlEnQ && !addrEnQ)) else $error("grant release order"); // R6

endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb #(
  parameter int PARK_CYCLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic relReqN,
  input  logic cycleDone,
  input  logic prechDone,
  input  logic refPending,
  output logic grantN,
  output logic addrDataEn,
  output logic ctrlEn,
  output logic ctrlParkHigh,
  output logic refWaitReq,
  output logic busIdle
);

  brel_pkg::brelStrobe_t stb;

  brel_ctrl #(.PARK_CYCLES(PARK_CYCLES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .relReqN   (relReqN),
    .cycleDone (cycleDone),
    .prechDone (prechDone),
    .stb       (stb),
    .busIdle   (busIdle)
  );

  brel_datapath #(.PARK_CYCLES(PARK_CYCLES)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .refPending   (refPending),
    .grantN       (grantN),
    .addrDataEn   (addrDataEn),
    .ctrlEn       (ctrlEn),
    .ctrlParkHigh (ctrlParkHigh),
    .refWaitReq   (refWaitReq)
  );

  AST_IDLE_MEANS_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> (grantN && addrDataEn && ctrlEn)) else $error("idle while handing over"); // R9

  AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrDataEn) |-> ($past(cycleDone) && $past(prechDone))) else $error("released mid cycle"); // R3

  AST_REFWAIT_ONLY_AWAY: assert property (@(posedge clk) disable iff (!rstN)
    refWaitReq |-> !addrDataEn) else $error("refresh request while owned"); // R8

endmodule

// File: tb/bus_release_arb_test.sv
module bus_release_arb_test;

  localparam int CLK_PERIOD = 10;
  localparam int PARK = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic relReqN = 1'b1, cycleDone = 1'b1, prechDone = 1'b1, refPending = 1'b0;
  logic grantN, addrDataEn, ctrlEn, ctrlParkHigh, refWaitReq, busIdle;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  int mSt = 0, mCnt = 0;
  bit eGrantN = 1, eAddr = 1, eCtrl = 1, ePark = 0;

  bus_release_arb #(.PARK_CYCLES(PARK)) uut (
    .clk(clk), .rstN(rstN), .relReqN(relReqN), .cycleDone(cycleDone),
    .prechDone(prechDone), .refPending(refPending), .grantN(grantN),
    .addrDataEn(addrDataEn), .ctrlEn(ctrlEn), .ctrlParkHigh(ctrlParkHigh),
    .refWaitReq(refWaitReq), .busIdle(busIdle)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, edgeCnt);
    end
  endtask

  // Expected behaviour per edge, from the requirement timings. slot 0 = rise, 1 = fall.
  task automatic modelAdvance(int slot);
    case (mSt)
      0: if (slot == 1 && !relReqN) mSt = 1;
      1: if (slot == 1) begin
           if (relReqN) mSt = 0;
         end else if (cycleDone && prechDone) begin
           mSt = 2; mCnt = 0; eAddr = 0; ePark = 1;
         end
      2: if (slot == 1) begin
           if (mCnt == 0) eGrantN = 0;
         end else if (mCnt == PARK - 1) begin
           eCtrl = 0; mSt = 3;
         end else mCnt++;
      3: if (slot == 1 && relReqN) mSt = 4;
      4: if (slot == 0) begin eCtrl = 1; mSt = 5; end
      5: if (slot == 1) begin eGrantN = 1; mSt = 6; end
      6: if (slot == 0) begin eAddr = 1; ePark = 0; mSt = 0; end
      default: mSt = 0;
    endcase
  endtask

  function automatic bit expRefWait();
    return refPending && !eAddr;
  endfunction

  task automatic compareAll();
    chk("R4", "grantN", int'(grantN), int'(eGrantN));
    chk("R3", "addrDataEn", int'(addrDataEn), int'(eAddr));
    chk("R5", "ctrlEn", int'(ctrlEn), int'(eCtrl));
    chk("R5", "ctrlParkHigh", int'(ctrlParkHigh), int'(ePark));
    chk("R9", "busIdle", int'(busIdle), int'(mSt == 0));
    chk("R8", "refWaitReq", int'(refWaitReq), int'(expRefWait()));
  endtask

  task automatic step();
    modelAdvance(edgeCnt % 2);
    @(negedge clk);
    edgeCnt++;
    compareAll();
  endtask

  task automatic alignNextFall();
    if (edgeCnt % 2 == 0) step();
  endtask

  task automatic alignNextRise();
    if (edgeCnt % 2 == 1) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", edgeCnt);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1", "grantN", int'(grantN), 1);
    chk("R1", "addrDataEn", int'(addrDataEn), 1);
    chk("R1", "ctrlEn", int'(ctrlEn), 1);
    chk("R1", "busIdle", int'(busIdle), 1);
    chk("R1", "ctrlParkHigh", int'(ctrlParkHigh), 0);
    chk("R1", "refWaitReq", int'(refWaitReq), 0);

    // R2: low only across a rise slot is not seen
    alignNextRise();
    relReqN = 1'b0;
    step();
    relReqN = 1'b1;
    step();
    chk("R2", "busIdle after rise-only request", int'(busIdle), 1);
    relReqN = 1'b0;
    cycleDone = 1'b0;
    alignNextFall();
    step();
    chk("R2", "busIdle after fall-slot request", int'(busIdle), 0);

    // R3: stall on cycleDone, then on prechDone
    repeat (5) step();
    chk("R3", "addrDataEn while cycle busy", int'(addrDataEn), 1);
    cycleDone = 1'b1;
    prechDone = 1'b0;
    repeat (4) step();
    chk("R3", "addrDataEn while precharging", int'(addrDataEn), 1);
    chk("R3", "grantN while precharging", int'(grantN), 1);
    prechDone = 1'b1;
    alignNextRise();
    step();
    chk("R4", "addrDataEn at T", int'(addrDataEn), 0);
    chk("R5", "park at T", int'(ctrlParkHigh), 1);
    chk("R4", "grantN at T", int'(grantN), 1);
    step();
    chk("R4", "grantN at T+1", int'(grantN), 0);
    for (int i = 2; i < 2 * PARK; i++) begin
      step();
      chk("R4", "ctrlEn before T+2P", int'(ctrlEn), 1);
    end
    refPending = 1'b1;
    step();
    chk("R4", "ctrlEn at T+2P", int'(ctrlEn), 0);
    chk("R8", "refWaitReq while away", int'(refWaitReq), 1);
    refPending = 1'b0;
    step();
    chk("R8", "refWaitReq no refresh", int'(refWaitReq), 0);
    refPending = 1'b1;

    // R6: take-back order
    alignNextFall();
    relReqN = 1'b1;
    step();
    chk("R6", "ctrlEn at F", int'(ctrlEn), 0);
    step();
    chk("R6", "ctrlEn at F+1", int'(ctrlEn), 1);
    chk("R6", "grantN at F+1", int'(grantN), 0);
    step();
    chk("R6", "grantN at F+2", int'(grantN), 1);
    chk("R6", "addrDataEn at F+2", int'(addrDataEn), 0);
    step();
    chk("R6", "addrDataEn at F+3", int'(addrDataEn), 1);
    chk("R6", "park at F+3", int'(ctrlParkHigh), 0);
    chk("R9", "busIdle at F+3", int'(busIdle), 1);
    chk("R8", "refWaitReq once owned", int'(refWaitReq), 0);
    refPending = 1'b0;

    // R7: abandon while waiting
    cycleDone = 1'b0;
    alignNextFall();
    relReqN = 1'b0;
    step();
    step();
    relReqN = 1'b1;
    step();
    chk("R7", "busIdle after abandon", int'(busIdle), 1);
    cycleDone = 1'b1;
    repeat (6) begin
      step();
      chk("R7", "grantN after abandon", int'(grantN), 1);
      chk("R7", "addrDataEn after abandon", int'(addrDataEn), 1);
    end

    // R10: request withdrawn during the park window
    alignNextFall();
    relReqN = 1'b0;
    step();
    step();
    relReqN = 1'b1;
    for (int i = 1; i < 2 * PARK; i++) step();
    step();
    chk("R10", "ctrlEn still floats", int'(ctrlEn), 0);
    step();
    step();
    chk("R10", "take-back started", int'(ctrlEn), 1);
    repeat (4) step();
    chk("R10", "owned again", int'(busIdle), 1);

    // Random phase checked against the model on every edge
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(11) == 0) relReqN = ~relReqN;
      cycleDone  = ($urandom_range(2) != 0);
      prechDone  = ($urandom_range(3) != 0);
      if ($urandom_range(19) == 0) refPending = ~refPending;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule